// File: doc/BRIEF.md
# Multi-Bank Chip-Select Address Decoder

This block sits between a bus master and a set of external memory regions. Software programs up to twelve banks. Each bank has a base word and a mask word. For every bus access the block compares the upper address bits with each enabled bank's base. The comparison covers only the bits that the bank's mask selects.

The block drives at most one chip-select line. It also reports the attributes of the winning bank: the memory controller type that should serve the access, the data port width and the error-correction mode. A write that lands on a write-protected bank is refused. In that case the block raises a fault flag and drives no chip select.

The decode path from address to outputs is purely combinational. Only the configuration words are stored, and a configuration write becomes visible on the clock edge that samples it.

Top module: `cs_bank_decoder`

## Requirements
- R1: After reset every base and mask word reads back as zero, and no access produces a hit, a chip select or a fault.
- R2: A base write to bank b (cfg_sel=0) is stored on the clock edge that samples it. The stored word keeps only bits 31:15, 12:0 restricted to 12:5, and bit 0; every other bit reads back as zero.
- R3: A mask write (cfg_sel=1) keeps only bits 31:15; all lower bits read back as zero.
- R4: Bank b hits when its enable bit (base bit 0) is 1, acc_valid is 1, and ((acc_addr XOR base) AND mask) is zero over bits 31:15. A mask of zero therefore matches every address.
- R5: A bank whose enable bit is 0 never hits, whatever its base and mask hold.
- R6: When several banks hit, only the lowest-numbered one drives its chip-select bit (bit b of cs for bank b), so cs is one-hot or zero.
- R7: On a hit, the outputs carry fields of the winning bank's base word. mem_type is taken from bits 7:5, with codes 000 general-purpose, 001 flash, 011 SDRAM, 100/101/110 programmable machines A/B/C. port_size is taken from bits 12:11, with codes 01=8, 10=16, 11=32 bits. ecc_mode is taken from bits 10:9, with codes 00 off, 01 check, 10 check+generate. All three read zero when there is no hit.
- R8: If the winning bank has write-protect (base bit 8) set and acc_write is 1, the block sets wp_fault to 1 and cs to all zero, while hit and the attributes stay reported. A read access to the same bank selects it normally.
- R9: With acc_valid at 0, hit, cs and wp_fault are all zero.
- R10: A configuration write with cfg_bank at or above the bank count changes no bank, and reads at such an index return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Selects the word: 0 base, 1 mask |
| cfg_bank | input | 4 | Bank index for both write and readback |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected word (combinational) |
| acc_valid | input | 1 | An access is present |
| acc_write | input | 1 | The access is a write |
| acc_addr | input | 32 | Access address |
| cs | output | 12 | One-hot chip selects |
| hit | output | 1 | Some enabled bank matched |
| mem_type | output | 3 | Controller type of the winning bank |
| port_size | output | 2 | Port width code of the winning bank |
| ecc_mode | output | 2 | ECC mode of the winning bank |
| wp_fault | output | 1 | Write hit a write-protected bank |

## Verification
The bench builds the block with its default values of twelve banks and a match boundary at bit 15. These values make the highest bank index and the out-of-range indices 12 to 15 reachable through the 4-bit bank port. The boundary at bit 15 means the bench can show that a difference in bits 14:0 never prevents a hit. Overlapping windows and an all-zero mask bring the priority and match-everything cases within reach.

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder #(
  parameter int NBANK   = 12,
  parameter int TAG_LSB = 15,
  parameter int BW      = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [BW-1:0]    cfg_bank,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [31:0]      acc_addr,
  output logic [NBANK-1:0] cs,
  output logic             hit,
  output logic [2:0]       mem_type,
  output logic [1:0]       port_size,
  output logic [1:0]       ecc_mode,
  output logic             wp_fault
);

  localparam logic [31:0] TAG_M     = ~((32'd1 << TAG_LSB) - 32'd1);
  localparam logic [31:0] ATTR_M    = 32'h0000_1FE1;
  localparam logic [31:0] BASE_KEEP = TAG_M | ATTR_M;

  logic [31:0] base_q [NBANK];
  logic [31:0] mask_q [NBANK];
  logic [NBANK-1:0] raw;
  logic [NBANK-1:0] win;
  logic [7:0] attr;
  logic in_range;

  assign in_range = int'(cfg_bank) < NBANK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (cfg_we && in_range) begin
      if (cfg_sel) mask_q[cfg_bank] <= cfg_wdata & TAG_M;
      else         base_q[cfg_bank] <= cfg_wdata & BASE_KEEP;
    end
  end

  assign cfg_rdata = !in_range ? '0 : (cfg_sel ? mask_q[cfg_bank] : base_q[cfg_bank]);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign raw[g] = acc_valid && base_q[g][0] &&
                    (((acc_addr ^ base_q[g]) & mask_q[g] & TAG_M) == 32'd0);
  end

  always_comb begin
    win  = '0;
    attr = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (raw[i]) begin
        win     = '0;
        win[i]  = 1'b1;
        attr    = base_q[i][12:5];
      end
    end
  end

  assign hit       = |raw;
  assign wp_fault  = hit && acc_write && attr[3];
  assign cs        = wp_fault ? '0 : win;
  assign mem_type  = attr[2:0];
  assign ecc_mode  = attr[5:4];
  assign port_size = attr[7:6];

endmodule

// File: rtl/cs_bank_decoder_chk.sv
module cs_bank_decoder_chk #(
  parameter int NBANK   = 12,
  parameter int TAG_LSB = 15,
  parameter int BW      = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_sel,
  input logic [BW-1:0]    cfg_bank,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [31:0]      acc_addr,
  input logic [NBANK-1:0] cs,
  input logic             hit,
  input logic [2:0]       mem_type,
  input logic [1:0]       port_size,
  input logic [1:0]       ecc_mode,
  input logic             wp_fault
);

  localparam logic [31:0] TAG_M  = ~((32'd1 << TAG_LSB) - 32'd1);
  localparam logic [31:0] KEEP_B = TAG_M | 32'h0000_1FE1;

  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cfg_we) && int'($past(cfg_bank)) < NBANK && !$past(cfg_sel) &&
     cfg_bank == $past(cfg_bank) && !cfg_sel)
    |-> cfg_rdata == ($past(cfg_wdata) & KEEP_B));

  p_mask_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cfg_we) && int'($past(cfg_bank)) < NBANK && $past(cfg_sel) &&
     cfg_bank == $past(cfg_bank) && cfg_sel)
    |-> cfg_rdata == ($past(cfg_wdata) & TAG_M));

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));

  p_cs_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != '0) |-> hit);

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (mem_type == 3'd0 && port_size == 2'd0 && ecc_mode == 2'd0));

  p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_fault |-> (cs == '0 && hit && acc_write));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!hit && cs == '0 && !wp_fault));

  p_outside_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_bank) >= NBANK) |-> cfg_rdata == 32'd0);

  logic unused_ok;
  assign unused_ok = ^acc_addr;

endmodule

bind cs_bank_decoder cs_bank_decoder_chk #(.NBANK(NBANK), .TAG_LSB(TAG_LSB), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_bank(cfg_bank),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
  .acc_write(acc_write), .acc_addr(acc_addr), .cs(cs), .hit(hit),
  .mem_type(mem_type), .port_size(port_size), .ecc_mode(ecc_mode), .wp_fault(wp_fault)
);

// File: tb/cs_bank_decoder_tb.sv
`timescale 1ns/1ps
module cs_bank_decoder_tb;
  localparam int NB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [3:0] cfg_bank = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [NB-1:0] cs;
  logic hit, wp_fault;
  logic [2:0] mem_type;
  logic [1:0] port_size, ecc_mode;

  always #10 clk = ~clk;

  cs_bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_bank(cfg_bank),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .cs(cs), .hit(hit),
    .mem_type(mem_type), .port_size(port_size), .ecc_mode(ecc_mode), .wp_fault(wp_fault)
  );

  typedef struct {
    logic [NB-1:0] cs;
    logic hit;
    logic [2:0] mt;
    logic [1:0] ps;
    logic [1:0] ecc;
    logic wpf;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] sh_base [NB];
  logic [31:0] sh_mask [NB];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input bit wr, input bit v, input string tag);
    exp_t e;
    e.cs = '0; e.hit = 0; e.mt = 0; e.ps = 0; e.ecc = 0; e.wpf = 0; e.tag = tag;
    for (int i = 0; i < NB; i++) begin
      if (!e.hit && v && sh_base[i][0] &&
          (((a ^ sh_base[i]) & sh_mask[i]) >> 15) == 0) begin
        e.hit = 1;
        e.mt  = sh_base[i][7:5];
        e.ps  = sh_base[i][12:11];
        e.ecc = sh_base[i][10:9];
        e.wpf = wr && sh_base[i][8];
        e.cs  = e.wpf ? '0 : (NB'(1) << i);
      end
    end
    return e;
  endfunction

  task automatic wcfg(input int bank, input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_bank = 4'(bank); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (bank < NB) begin
      if (sel) sh_mask[bank] = d & 32'hFFFF_8000;
      else     sh_base[bank] = d & 32'hFFFF_9FE1;
    end
  endtask

  task automatic rcfg(input int bank, input bit sel, input logic [31:0] expv, input string tag);
    @(negedge clk);
    cfg_bank = 4'(bank); cfg_sel = sel;
    #2;
    chk(cfg_rdata === expv, tag, cfg_rdata, expv);
  endtask

  task automatic acc(input logic [31:0] a, input bit wr, input bit v, input string tag);
    @(negedge clk);
    acc_addr = a; acc_write = wr; acc_valid = v;
    q.push_back(model(a, wr, v, tag));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(cs === e.cs, {e.tag, " cs"}, 32'(cs), 32'(e.cs));
        n_run--;
        chk(hit === e.hit && wp_fault === e.wpf, {e.tag, " hit/wp_fault"},
            {30'd0, hit, wp_fault}, {30'd0, e.hit, e.wpf});
        n_run--;
        chk(mem_type === e.mt && port_size === e.ps && ecc_mode === e.ecc, {e.tag, " attributes"},
            {25'd0, mem_type, port_size, ecc_mode}, {25'd0, e.mt, e.ps, e.ecc});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(20 * 50000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin : stim
    for (int i = 0; i < NB; i++) begin sh_base[i] = '0; sh_mask[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rcfg(0, 0, 32'd0, "R1 base0 after reset");
    rcfg(11, 1, 32'd0, "R1 mask11 after reset");
    acc(32'h0000_0000, 0, 1, "R1 no hit after reset");
    // R2/R3: field masking on readback
    wcfg(3, 0, 32'hFFFF_FFFF);
    rcfg(3, 0, 32'hFFFF_9FE1, "R2 base reserved bits zero");
    wcfg(3, 1, 32'hFFFF_FFFF);
    rcfg(3, 1, 32'hFFFF_8000, "R3 mask low bits zero");
    wcfg(3, 0, 32'h0000_0000);
    wcfg(3, 1, 32'h0000_0000);
    // R4/R7: bank 2, SDRAM type 011, 32-bit 11, ecc check 01
    wcfg(2, 0, 32'h8000_0000 | 32'h1800 | 32'h0200 | 32'h0060 | 32'h1);
    wcfg(2, 1, 32'hF000_0000);
    acc(32'h8123_4567, 0, 1, "R4 R7 bank2 hit");
    acc(32'h9000_0000, 0, 1, "R4 bank2 miss");
    acc(32'h8000_7FFF, 1, 1, "R4 low bits ignored");
    // R5: disabled bank overlapping bank2 window, placed below it
    wcfg(1, 0, 32'h8000_0000 | 32'h0800);
    wcfg(1, 1, 32'hF000_0000);
    acc(32'h8000_0010, 0, 1, "R5 disabled bank1 ignored");
    // R6: bank5 enabled with wider window
    wcfg(5, 0, 32'h8000_0000 | 32'h1000 | 32'h0400 | 32'h0020 | 32'h1);
    wcfg(5, 1, 32'h8000_0000);
    acc(32'h8FFF_0000, 0, 1, "R6 bank2 beats bank5");
    acc(32'hC000_0000, 0, 1, "R6 only bank5");
    // R8: write-protected bank 7, type 100, 8-bit 01
    wcfg(7, 0, 32'h4000_0000 | 32'h0100 | 32'h0080 | 32'h0800 | 32'h1);
    wcfg(7, 1, 32'hFFFF_8000);
    acc(32'h4000_1234, 1, 1, "R8 write to protected");
    acc(32'h4000_1234, 0, 1, "R8 read of protected");
    acc(32'h4000_8000, 1, 1, "R8 write outside window");
    // R9: no access
    acc(32'h8123_4567, 0, 0, "R9 idle");
    acc(32'h4000_1234, 1, 0, "R9 idle write");
    // R10: out-of-range index
    wcfg(12, 0, 32'h0000_0001);
    wcfg(13, 1, 32'hFFFF_FFFF);
    rcfg(12, 0, 32'd0, "R10 read idx12");
    rcfg(0, 0, 32'd0, "R10 bank0 untouched");
    rcfg(4, 0, 32'd0, "R10 bank4 untouched");
    acc(32'h0000_0000, 0, 1, "R10 no new hit");
    // R4: mask zero matches all, highest bank
    wcfg(11, 0, 32'h1234_5000 | 32'h1);
    acc(32'h0000_0001, 0, 1, "R4 zero mask bank11");
    acc(32'h8123_4567, 0, 1, "R6 bank2 over bank11");
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule